// File: doc/BRIEF.md
# Ordered / Unordered Double-Precision Comparator

This block compares two 64-bit IEEE-754 double values and returns a one-hot 4-bit condition code that classifies the pair as less-than, greater-than, equal or unordered. A variant select picks between two compare flavours. The quiet flavour treats quiet NaN operands as a normal unordered outcome. The strict flavour treats any NaN operand as an invalid comparison. For each compare the block reports which invalid-operation reason bits the surrounding status logic must set. It also merges the new code into a caller-supplied status word, replacing only the 4-bit condition field.

A compare starts with a one-cycle `start` strobe. The code, the merged status word and all pulse outputs appear together one clock later, marked by `done`. When a strict compare is invalid and the invalid-operation enable is set, the trap is deferred. The block raises the enabled-exception summary together with the result, and it issues the exception request one further cycle later, after the code has been written. The status register itself lives outside this block.

Top module: `fp_cmp_unit`

## Requirements
- R1: `ccOut` is one-hot: 4'b1000 when A < B, 4'b0100 when A > B, 4'b0010 when A == B, and 4'b0001 when the pair is unordered (either operand is a NaN). Positive zero and negative zero compare equal.
- R2: Non-NaN operands are ordered by sign and magnitude. Any negative value, including negative infinity, is less than any positive one. Between two negative operands, the larger magnitude is the smaller value. Denormals and infinities order like any other value.
- R3: In the quiet variant (`orderedSel`=0), a signaling NaN operand asserts `rsnSnan` only. A signaling NaN has exponent all ones, a nonzero fraction and fraction bit 51 clear. A quiet NaN (fraction bit 51 set) asserts no reason bit.
- R4: In the strict variant (`orderedSel`=1), a signaling NaN operand asserts both `rsnSnan` and `rsnVc`, and a quiet NaN asserts `rsnVc` only.
- R5: Whenever a reason bit is asserted, the code delivered with it is 4'b0001 (unordered).
- R6: A strict compare that asserts `rsnVc` while `invEnable`=1 asserts `deferredExc` and `enSummary` with `done`. It then pulses `excReq` exactly one cycle after that `done`. `enSummary` also rises with any reason bit while `invEnable`=1 in the quiet variant, but `deferredExc` and `excReq` do not.
- R7: `done` and the reason, summary and deferral pulses are high in the single cycle after each cycle in which `start` is high, and low otherwise. `ccOut` and `statusOut` hold their values between compares.
- R8: On each compare, `statusOut` becomes `statusIn` (sampled with `start`) with bits [15:12] replaced by the new code. All other bits pass through unchanged.
- R9: During and right after reset, `ccOut` and `statusOut` are zero and every pulse output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a compare with the current operands |
| orderedSel | input | 1 | 1 = strict (ordered) variant, 0 = quiet (unordered) variant |
| invEnable | input | 1 | Invalid-operation trap enable |
| opA | input | 64 | First operand, IEEE double |
| opB | input | 64 | Second operand, IEEE double |
| statusIn | input | 32 | Current status word to merge the code into |
| ccOut | output | 4 | Condition code of the latest compare |
| statusOut | output | 32 | Status word with the condition field replaced |
| rsnSnan | output | 1 | Reason pulse: signaling-NaN operand |
| rsnVc | output | 1 | Reason pulse: invalid ordered compare |
| enSummary | output | 1 | Enabled-exception summary pulse |
| deferredExc | output | 1 | Trap is deferred until after the code write |
| excReq | output | 1 | Exception request, one cycle after a deferred result |
| done | output | 1 | Result valid strobe |

## Verification
The hardest situation to reach is the ordering of the deferred trap. The strict variant must meet a NaN with the enable set, and `excReq` must then follow `done` by exactly one cycle rather than coincide with it. The stimulus drives strict compares with signaling and quiet NaNs under both enable settings. It also issues back-to-back starts, so a deferred request overlaps the next result. Sign-magnitude corners (two negatives, mixed zeros, infinities, denormals) are reached by listing specific bit patterns. The reference model derives its expected order from real-number comparison.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  localparam logic [3:0] CC_LT  = 4'b1000;
  localparam logic [3:0] CC_GT  = 4'b0100;
  localparam logic [3:0] CC_EQ  = 4'b0010;
  localparam logic [3:0] CC_UN  = 4'b0001;

  // Classification and ordering info from datapath to control
  typedef struct packed {
    logic nanA;
    logic nanB;
    logic sigA;
    logic sigB;
    logic lt;
    logic gt;
    logic eq;
  } cmpInfo_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       load;
    logic [3:0] cc;
  } dpCtrl_t;

endpackage

// File: rtl/fpcmp_dp.sv
module fpcmp_dp
  import fpcmp_pkg::*;
#(
  parameter int EXP_W    = 11,
  parameter int FRAC_W   = 52,
  parameter int STATUS_W = 32,
  parameter int CC_LSB   = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [EXP_W+FRAC_W:0]      opA,
  input  logic [EXP_W+FRAC_W:0]      opB,
  input  logic [STATUS_W-1:0]        statusIn,
  input  dpCtrl_t                    ctl,
  output cmpInfo_t                   info,
  output logic [3:0]                 ccOut,
  output logic [STATUS_W-1:0]        statusOut
);

  localparam int DATA_W = EXP_W + FRAC_W + 1;
  localparam int MAG_W  = DATA_W - 1;
  localparam logic [STATUS_W-1:0] FIELD_MASK =
    {{(STATUS_W-4){1'b0}}, 4'hF} << CC_LSB;

  logic [DATA_W-1:0] ops  [2];
  logic [MAG_W-1:0]  magV [2];
  logic [1:0]        nanV;
  logic [1:0]        sigV;
  logic [1:0]        signV;
  logic [1:0]        zeroV;

  assign ops[0] = opA;
  assign ops[1] = opB;

  // Per-operand classification
  for (genvar i = 0; i < 2; i++) begin : g_cls
    logic expOnes;
    logic fracNz;
    assign expOnes  = &ops[i][MAG_W-1 -: EXP_W];
    assign fracNz   = |ops[i][FRAC_W-1:0];
    assign nanV[i]  = expOnes & fracNz;
    assign sigV[i]  = expOnes & fracNz & ~ops[i][FRAC_W-1];
    assign magV[i]  = ops[i][MAG_W-1:0];
    assign signV[i] = ops[i][DATA_W-1];
    assign zeroV[i] = ~|ops[i][MAG_W-1:0];
  end

  // Sign-magnitude ordering
  logic aBigger;
  logic magEq;
  logic ltC, gtC, eqC;

  assign aBigger = magV[0] > magV[1];
  assign magEq   = magV[0] == magV[1];

  always_comb begin
    ltC = 1'b0;
    gtC = 1'b0;
    eqC = 1'b0;
    if (zeroV[0] && zeroV[1]) begin
      eqC = 1'b1;
    end else if (signV[0] != signV[1]) begin
      ltC = signV[0];
      gtC = signV[1];
    end else if (magEq) begin
      eqC = 1'b1;
    end else if (signV[0]) begin
      ltC = aBigger;
      gtC = ~aBigger;
    end else begin
      ltC = ~aBigger;
      gtC = aBigger;
    end
  end

  assign info.nanA = nanV[0];
  assign info.nanB = nanV[1];
  assign info.sigA = sigV[0];
  assign info.sigB = sigV[1];
  assign info.lt   = ltC;
  assign info.gt   = gtC;
  assign info.eq   = eqC;

  // Result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ccOut     <= '0;
      statusOut <= '0;
    end else if (ctl.load) begin
      ccOut     <= ctl.cc;
      statusOut <= (statusIn & ~FIELD_MASK)
                 | ({{(STATUS_W-4){1'b0}}, ctl.cc} << CC_LSB);
    end
  end

  // R1
  cc_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ccOut));

  // R8
  status_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.load) |-> ((statusOut & ~FIELD_MASK) == ($past(statusIn) & ~FIELD_MASK)));

  // R7
  cc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.load) |-> $stable(ccOut));

endmodule

// File: rtl/fpcmp_ctrl.sv
module fpcmp_ctrl
  import fpcmp_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     orderedSel,
  input  logic     invEnable,
  input  cmpInfo_t info,
  output dpCtrl_t  ctl,
  output logic     done,
  output logic     rsnSnan,
  output logic     rsnVc,
  output logic     enSummary,
  output logic     deferredExc,
  output logic     excReq
);

  logic anyNan, anySig;
  logic snanHit, vcHit, invalidHit;
  logic deferHit, enHit;
  logic [3:0] ccSel;

  assign anyNan     = info.nanA | info.nanB;
  assign anySig     = info.sigA | info.sigB;
  assign snanHit    = anySig;
  assign vcHit      = orderedSel & anyNan;
  assign invalidHit = snanHit | vcHit;
  assign deferHit   = vcHit & invEnable;
  assign enHit      = invalidHit & invEnable;

  always_comb begin
    if (anyNan || invalidHit) ccSel = CC_UN;
    else if (info.lt)         ccSel = CC_LT;
    else if (info.gt)         ccSel = CC_GT;
    else if (info.eq)         ccSel = CC_EQ;
    else                      ccSel = CC_UN;
  end

  assign ctl.load = start;
  assign ctl.cc   = ccSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done        <= 1'b0;
      rsnSnan     <= 1'b0;
      rsnVc       <= 1'b0;
      enSummary   <= 1'b0;
      deferredExc <= 1'b0;
      excReq      <= 1'b0;
    end else begin
      done        <= start;
      rsnSnan     <= start & snanHit;
      rsnVc       <= start & vcHit;
      enSummary   <= start & enHit;
      deferredExc <= start & deferHit;
      excReq      <= done & deferredExc;
    end
  end

  // R7
  done_after_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(start));

  // R7
  pulse_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> !(rsnSnan || rsnVc || enSummary || deferredExc));

  // R4
  vc_only_strict_chk: assert property (@(posedge clk) disable iff (!rstN)
    rsnVc |-> $past(orderedSel));

  // R6
  defer_needs_vc_chk: assert property (@(posedge clk) disable iff (!rstN)
    deferredExc |-> (rsnVc && enSummary && done));

  // R6
  exc_after_defer_chk: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> $past(done && deferredExc));

endmodule

// File: rtl/fp_cmp_unit.sv
module fp_cmp_unit
  import fpcmp_pkg::*;
#(
  parameter int EXP_W    = 11,
  parameter int FRAC_W   = 52,
  parameter int STATUS_W = 32,
  parameter int CC_LSB   = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic                      orderedSel,
  input  logic                      invEnable,
  input  logic [EXP_W+FRAC_W:0]     opA,
  input  logic [EXP_W+FRAC_W:0]     opB,
  input  logic [STATUS_W-1:0]       statusIn,
  output logic [3:0]                ccOut,
  output logic [STATUS_W-1:0]       statusOut,
  output logic                      rsnSnan,
  output logic                      rsnVc,
  output logic                      enSummary,
  output logic                      deferredExc,
  output logic                      excReq,
  output logic                      done
);

  cmpInfo_t info;
  dpCtrl_t  ctl;

  fpcmp_dp #(
    .EXP_W(EXP_W), .FRAC_W(FRAC_W), .STATUS_W(STATUS_W), .CC_LSB(CC_LSB)
  ) u_dp (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .statusIn(statusIn),
    .ctl(ctl), .info(info), .ccOut(ccOut), .statusOut(statusOut)
  );

  fpcmp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .orderedSel(orderedSel),
    .invEnable(invEnable), .info(info), .ctl(ctl), .done(done),
    .rsnSnan(rsnSnan), .rsnVc(rsnVc), .enSummary(enSummary),
    .deferredExc(deferredExc), .excReq(excReq)
  );

  // R5
  invalid_unordered_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rsnSnan || rsnVc) |-> (ccOut == CC_UN));

endmodule

// File: tb/sim_fp_cmp_unit.sv
module sim_fp_cmp_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        orderedSel = 1'b0;
  logic        invEnable = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [31:0] statusIn = '0;
  logic [3:0]  ccOut;
  logic [31:0] statusOut;
  logic        rsnSnan, rsnVc, enSummary, deferredExc, excReq, done;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string curTag = "R1";
  string expTag = "R1";

  always #2 clk = ~clk;

  fp_cmp_unit u0 (
    .clk(clk), .rstN(rstN), .start(start), .orderedSel(orderedSel),
    .invEnable(invEnable), .opA(opA), .opB(opB), .statusIn(statusIn),
    .ccOut(ccOut), .statusOut(statusOut), .rsnSnan(rsnSnan), .rsnVc(rsnVc),
    .enSummary(enSummary), .deferredExc(deferredExc), .excReq(excReq),
    .done(done)
  );

  function automatic bit isNan(input logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
  endfunction

  function automatic bit isSig(input logic [63:0] v);
    return isNan(v) && !v[51];
  endfunction

  function automatic logic [3:0] refCc(input logic [63:0] a, input logic [63:0] b);
    real ra, rb;
    if (isNan(a) || isNan(b)) return 4'b0001;
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    if (ra < rb) return 4'b1000;
    if (ra > rb) return 4'b0100;
    return 4'b0010;
  endfunction

  // Behavioural reference model, one step per clock
  logic [3:0]  mCc;
  logic [31:0] mStat;
  logic mDone, mSn, mVc, mEn, mDef, mExc;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCc <= 0; mStat <= 0; mDone <= 0; mSn <= 0; mVc <= 0;
      mEn <= 0; mDef <= 0; mExc <= 0;
    end else begin
      bit sn, vc;
      sn = isSig(opA) || isSig(opB);
      vc = orderedSel && (isNan(opA) || isNan(opB));
      mExc  <= mDone && mDef;
      mDone <= start;
      mSn   <= start && sn;
      mVc   <= start && vc;
      mEn   <= start && (sn || vc) && invEnable;
      mDef  <= start && vc && invEnable;
      if (start) begin
        mCc    <= refCc(opA, opB);
        mStat  <= {statusIn[31:16], refCc(opA, opB), statusIn[11:0]};
        expTag <= curTag;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    chk(ccOut == mCc, (expTag == "R1") ? "R1 code" : {expTag, " code"},
        {28'd0, ccOut}, {28'd0, mCc});
    chk(statusOut == mStat, "R8 status merge", statusOut, mStat);
    chk(done == mDone, "R7 done", {31'd0, done}, {31'd0, mDone});
    chk(rsnSnan == mSn, "R3 snan reason", {31'd0, rsnSnan}, {31'd0, mSn});
    chk(rsnVc == mVc, "R4 vc reason", {31'd0, rsnVc}, {31'd0, mVc});
    chk(enSummary == mEn, "R6 summary", {31'd0, enSummary}, {31'd0, mEn});
    chk(deferredExc == mDef, "R6 deferred", {31'd0, deferredExc}, {31'd0, mDef});
    chk(excReq == mExc, "R6 request", {31'd0, excReq}, {31'd0, mExc});
    if ((rsnSnan || rsnVc) && ccOut != 4'b0001)
      chk(1'b0, "R5 forced unordered", {28'd0, ccOut}, 32'h1);
  end

  task automatic cmp(input logic [63:0] a, input logic [63:0] b, input bit ord,
                     input bit ve, input logic [31:0] st, input string tag);
    @(negedge clk);
    opA = a; opB = b; orderedSel = ord; invEnable = ve; statusIn = st;
    curTag = tag; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  localparam logic [63:0] P1   = 64'h3FF0000000000000;
  localparam logic [63:0] P2   = 64'h4000000000000000;
  localparam logic [63:0] N1   = 64'hBFF0000000000000;
  localparam logic [63:0] N2   = 64'hC000000000000000;
  localparam logic [63:0] PZ   = 64'h0000000000000000;
  localparam logic [63:0] NZ   = 64'h8000000000000000;
  localparam logic [63:0] PINF = 64'h7FF0000000000000;
  localparam logic [63:0] NINF = 64'hFFF0000000000000;
  localparam logic [63:0] QNAN = 64'h7FF8000000000000;
  localparam logic [63:0] NQNN = 64'hFFF8000000000001;
  localparam logic [63:0] SNAN = 64'h7FF0000000000001;
  localparam logic [63:0] DEN  = 64'h0000000000000001;

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(ccOut == 0 && statusOut == 0 && !done && !excReq && !deferredExc,
        "R9 reset", statusOut, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(ccOut == 0 && !done && !rsnSnan && !rsnVc && !enSummary,
        "R9 after reset", {28'd0, ccOut}, 32'h0);

    cmp(P1, P2, 0, 0, 32'hFFFFFFFF, "R1");
    cmp(P2, P1, 1, 1, 32'h12345678, "R1");
    cmp(P1, P1, 0, 0, 32'hA5A5A5A5, "R1");
    cmp(PZ, NZ, 1, 0, 32'h0000F000, "R1");
    cmp(NZ, PZ, 0, 1, 32'h00000000, "R1");
    cmp(N1, N2, 0, 0, 32'h0F0F0F0F, "R2");
    cmp(N2, N1, 1, 0, 32'hDEADBEEF, "R2");
    cmp(NINF, P1, 0, 0, 32'h00000001, "R2");
    cmp(PINF, P2, 1, 1, 32'h80000000, "R2");
    cmp(DEN, PZ, 0, 0, 32'h00010000, "R2");
    cmp(N1, DEN, 1, 0, 32'h00008000, "R2");
    cmp(PINF, PINF, 0, 0, 32'h11111111, "R2");
    cmp(QNAN, P1, 0, 0, 32'h22222222, "R3");
    cmp(P1, SNAN, 0, 0, 32'h33333333, "R3");
    cmp(SNAN, QNAN, 0, 1, 32'h44444444, "R3");
    cmp(NQNN, P1, 0, 1, 32'h55555555, "R3");
    cmp(SNAN, P1, 1, 0, 32'h66666666, "R4");
    cmp(P1, QNAN, 1, 0, 32'h77777777, "R4");
    cmp(QNAN, SNAN, 1, 1, 32'h88888888, "R6");
    cmp(NQNN, NQNN, 1, 1, 32'h99999999, "R6");
    cmp(P1, N1, 1, 1, 32'hAAAAAAAA, "R6");

    // Back-to-back starts: deferred request overlaps the next result (R6, R7)
    @(negedge clk);
    opA = QNAN; opB = P1; orderedSel = 1; invEnable = 1; statusIn = 32'hBBBBBBBB;
    curTag = "R6"; start = 1'b1;
    @(negedge clk);
    opA = N2; opB = NINF; orderedSel = 0; invEnable = 1; statusIn = 32'hCCCCCCCC;
    curTag = "R2";
    @(negedge clk);
    opA = SNAN; opB = SNAN; orderedSel = 1; invEnable = 1; curTag = "R5";
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule